// File: doc/BRIEF.md
# DDR2 Write-Burst Byte-Mask Generator

This block turns one write request into the data and byte-mask stream for a single DDR2 write burst. A request carries up to eight 32-bit words, a byte-enable nibble for each word, and a length. When the write command strobe is accepted, the block waits for the write latency, which is the CAS latency minus one. It then emits exactly eight beats, one per cycle, at the half-rate logical level. Beats beyond the requested length are fully masked. Byte lanes whose enable is clear are masked too. The DQM stream therefore lets the memory ignore every byte that the request does not cover.

A mode input selects a 32-bit or a 16-bit external device. The memory is right aligned on the data bus, so a 16-bit device uses only the two low byte lanes. The two high lanes are then always masked and driven with zero data. All request fields and the latency setting are captured at acceptance. A busy flag holds off new requests until the eighth beat has been presented.

Top module: `ddr_wm_gen`

## Requirements
- R1: While reset is active, and after it, the block is idle: `busy`=0, `beat_valid`=0, `burst_last`=0, `beat_dqm`=4'hF and `beat_data`=0. A reset asserted mid-burst ends the burst at the next clock edge.
- R2: A request is accepted in a cycle where `req_valid`=1 and `busy`=0. From the next cycle, `busy` stays 1 through the cycle of the eighth beat. It is 0 in the cycle after that, so a held request is accepted there.
- R3: A request presented while `busy`=1 is ignored and never starts a burst.
- R4: Let the accept cycle be cycle 0 and WL the CAS latency minus one. Beat 0 is presented in cycle WL.
- R5: A `cas_lat` value below 2 is used as 2, and a value above 5 is used as 5. WL therefore lies in 1..4.
- R6: Every burst has exactly eight beats in consecutive cycles, whatever the length. `burst_last` is 1 only on the eighth beat.
- R7: `req_len` holds the word count minus one (0..7 means 1..8 words). Word k is `req_data[32k+31:32k]` and goes out on beat k. A beat k > `req_len` has `beat_dqm`=4'hF and `beat_data`=0.
- R8: A DQM bit is active high, and a 1 means the lane is masked. Lane i is `beat_data[8i+7:8i]`. On an active beat k, `beat_dqm[i]` is the inverse of `req_be[4k+i]`. Data bytes are passed unchanged whether masked or not.
- R9: With `mode_x16`=1 (16-bit device), lanes 2 and 3 are always masked and `beat_data[31:16]`=0 on every beat.
- R10: Outside a burst's eight beats, `beat_dqm`=4'hF, `beat_data`=0 and `burst_last`=0.
- R11: Data, enables, length, mode and latency are captured at acceptance. Later changes on those inputs do not affect the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write command strobe / request valid |
| req_len | input | 3 | Word count minus one |
| req_data | input | 256 | Eight words, word k at bits [32k+31:32k] |
| req_be | input | 32 | Byte enables, word k at bits [4k+3:4k] |
| mode_x16 | input | 1 | 1 = 16-bit device on lanes 0 and 1 |
| cas_lat | input | 3 | Programmed CAS latency (clamped to 2..5) |
| busy | output | 1 | Burst pending; new requests blocked |
| beat_valid | output | 1 | A burst beat is presented this cycle |
| beat_data | output | 32 | Beat data |
| beat_dqm | output | 4 | Per-lane mask, 1 = do not write |
| burst_last | output | 1 | Eighth beat of the burst |

## Verification
Some properties are checked on every cycle, independently of any particular request:
- the full mask outside bursts;
- the forced mask on the upper lanes in 16-bit mode;
- the rise of `busy` after acceptance and its fall after the last beat;
- the contiguity of the eight beats and the position of `burst_last`;
- the distance from acceptance to the first beat, including clamping.

Only the bench scenarios can show the rest:
- the byte-exact mapping of words and enables to beats and lanes;
- the masking of beats beyond the length;
- that a request made during a burst is dropped;
- that inputs changed after acceptance leave the burst untouched.

// File: rtl/ddr_wm_pkg.sv
// Shared types and helpers for the write-burst byte-mask generator.
// Assumes a 3-bit CAS latency setting; the legal range is CL_MIN..CL_MAX.
package ddr_wm_pkg;

    localparam int CL_MIN = 2;
    localparam int CL_MAX = 5;

    typedef logic [2:0] cl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_BEAT = 2'd2
    } seq_state_t;

    // Write latency from a CAS latency, with the CAS latency clamped to its legal range
    function automatic cl_t wl_from_cl(input cl_t cl);
        if (cl < cl_t'(CL_MIN))
            return cl_t'(CL_MIN - 1);
        else if (cl > cl_t'(CL_MAX))
            return cl_t'(CL_MAX - 1);
        else
            return cl - cl_t'(1);
    endfunction

endpackage

// File: rtl/wm_burst_seq.sv
// Burst sequencer: after start, waits wl cycles (counted so that beat 0
// lands wl cycles after the start cycle), then steps through BURST beats.
// Assumes wl >= 1; a wl of 0 is treated as 1.
module wm_burst_seq
    import ddr_wm_pkg::*;
#(
    parameter int BURST = 8,
    parameter int WL_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [WL_W-1:0]          wl,
    output logic                     busy,
    output logic                     beat_valid,
    output logic [$clog2(BURST)-1:0] beat_idx,
    output logic                     beat_last
);

    localparam int IDX_W = $clog2(BURST);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST - 1);

    seq_state_t       state;
    logic [WL_W-1:0]  wait_cnt;
    logic [IDX_W-1:0] idx;

    // State, latency countdown and beat index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            wait_cnt <= '0;
            idx      <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        idx      <= '0;
                        wait_cnt <= wl - WL_W'(1);
                        state    <= (wl <= WL_W'(1)) ? SEQ_BEAT : SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (wait_cnt <= WL_W'(1))
                        state <= SEQ_BEAT;
                    else
                        wait_cnt <= wait_cnt - WL_W'(1);
                end
                SEQ_BEAT: begin
                    if (idx == LAST_IDX)
                        state <= SEQ_IDLE;
                    else
                        idx <= idx + IDX_W'(1);
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Status decode
    always_comb begin
        busy       = (state != SEQ_IDLE);
        beat_valid = (state == SEQ_BEAT);
        beat_idx   = idx;
        beat_last  = (state == SEQ_BEAT) && (idx == LAST_IDX);
    end

endmodule

// File: rtl/wm_lane_mask.sv
// One byte lane: builds the lane's mask bit and data byte for the current beat.
// UPPER marks a lane that a 16-bit device does not use.
module wm_lane_mask #(
    parameter int LANE_W = 8,
    parameter bit UPPER  = 1'b0
) (
    input  logic              beat_on,
    input  logic              mode_x16,
    input  logic              lane_en,
    input  logic [LANE_W-1:0] din,
    output logic              dqm,
    output logic [LANE_W-1:0] dout
);

    logic lane_used;

    generate
        if (UPPER) begin : g_upper
            // Upper lane: absent on a 16-bit device
            always_comb lane_used = !mode_x16;
        end else begin : g_lower
            // Lower lane: always present
            always_comb begin
                lane_used = 1'b1;
            end
            logic unused_mode;
            assign unused_mode = mode_x16;
        end
    endgenerate

    // Mask is active high; data passes only on a live beat of a used lane
    always_comb begin
        dqm  = !(beat_on && lane_used && lane_en);
        dout = (beat_on && lane_used) ? din : '0;
    end

endmodule

// File: rtl/ddr_wm_gen.sv
// Write-burst byte-mask generator top. Captures a request of 1..BURST words
// with per-byte enables, then emits a fixed BURST-beat stream of data and
// active-high DQM starting at write latency (CAS latency - 1).
// Assumes DATA_W is a multiple of 8 with an even number of lanes.
module ddr_wm_gen
    import ddr_wm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BURST  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [$clog2(BURST)-1:0]      req_len,
    input  logic [BURST*DATA_W-1:0]       req_data,
    input  logic [BURST*(DATA_W/8)-1:0]   req_be,
    input  logic                          mode_x16,
    input  logic [2:0]                    cas_lat,
    output logic                          busy,
    output logic                          beat_valid,
    output logic [DATA_W-1:0]             beat_data,
    output logic [DATA_W/8-1:0]           beat_dqm,
    output logic                          burst_last
);

    localparam int NB    = DATA_W / 8;
    localparam int IDX_W = $clog2(BURST);

    logic                    accept;
    cl_t                     wl_eff;
    logic [BURST*DATA_W-1:0] data_q;
    logic [BURST*NB-1:0]     be_q;
    logic [IDX_W-1:0]        len_q;
    logic                    mode_q;
    logic [IDX_W-1:0]        beat_idx;
    logic                    beat_on;
    logic [DATA_W-1:0]       cur_word;
    logic [NB-1:0]           cur_be;

    // Acceptance and latency selection
    always_comb begin
        accept = req_valid && !busy;
        wl_eff = wl_from_cl(cas_lat);
    end

    // Request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            be_q   <= '0;
            len_q  <= '0;
            mode_q <= 1'b0;
        end else if (accept) begin
            data_q <= req_data;
            be_q   <= req_be;
            len_q  <= req_len;
            mode_q <= mode_x16;
        end
    end

    wm_burst_seq #(
        .BURST (BURST),
        .WL_W  (3)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .wl         (wl_eff),
        .busy       (busy),
        .beat_valid (beat_valid),
        .beat_idx   (beat_idx),
        .beat_last  (burst_last)
    );

    // Current word, enables and length gate
    always_comb begin
        cur_word = data_q[beat_idx*DATA_W +: DATA_W];
        cur_be   = be_q[beat_idx*NB +: NB];
        beat_on  = beat_valid && (beat_idx <= len_q);
    end

    for (genvar ln = 0; ln < NB; ln++) begin : g_lane
        wm_lane_mask #(
            .LANE_W (8),
            .UPPER  (ln >= NB/2)
        ) u_lane (
            .beat_on  (beat_on),
            .mode_x16 (mode_q),
            .lane_en  (cur_be[ln]),
            .din      (cur_word[ln*8 +: 8]),
            .dqm      (beat_dqm[ln]),
            .dout     (beat_data[ln*8 +: 8])
        );
    end

endmodule

// File: rtl/ddr_wm_gen_chk.sv
// Cycle-level checker for ddr_wm_gen, bound to every instance.
// Tracks cycles since acceptance and beats within a burst with its own counters.
module ddr_wm_gen_chk #(
    parameter int NB    = 4,
    parameter int BURST = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    cas_lat,
    input logic          busy,
    input logic          beat_valid,
    input logic [NB-1:0] beat_dqm,
    input logic          burst_last,
    input logic          mode_q
);

    logic [3:0] since_acc;
    logic [3:0] exp_wl_q;
    logic [3:0] beat_cnt;

    // Cycles since acceptance and the latency expected from the clamped setting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_acc <= '0;
            exp_wl_q  <= '0;
        end else if (req_valid && !busy) begin
            since_acc <= 4'd1;
            exp_wl_q  <= (cas_lat < 3'd2) ? 4'd1 :
                         (cas_lat > 3'd5) ? 4'd4 : {1'b0, cas_lat} - 4'd1;
        end else if (since_acc != 4'hF) begin
            since_acc <= since_acc + 4'd1;
        end
    end

    // Beats seen so far in the current run of valid beats
    always_ff @(posedge clk) begin
        if (!rst_n || !beat_valid)
            beat_cnt <= '0;
        else
            beat_cnt <= beat_cnt + 4'd1;
    end

    a_r10_idle_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> (beat_dqm == {NB{1'b1}} && !burst_last));

    a_r9_x16_upper_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && mode_q) |-> (beat_dqm[NB-1:NB/2] == {(NB/2){1'b1}}));

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    a_r2_free_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last |=> !busy);

    a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !burst_last) |=> beat_valid);

    a_r6_last_is_eighth: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last |-> (beat_cnt == 4'(BURST - 1)));

    a_r4_first_beat_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> (since_acc == exp_wl_q)); // also covers R5 clamping

endmodule

bind ddr_wm_gen ddr_wm_gen_chk #(.NB(DATA_W/8), .BURST(BURST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cas_lat    (cas_lat),
    .busy       (busy),
    .beat_valid (beat_valid),
    .beat_dqm   (beat_dqm),
    .burst_last (burst_last),
    .mode_q     (mode_q)
);

// File: tb/ddr_wm_gen_bench.sv
`timescale 1ns/1ps
module ddr_wm_gen_bench;

    localparam int NV = 8;
    localparam logic [2:0]  V_LEN [NV] = '{3'd7, 3'd0, 3'd3, 3'd7, 3'd4, 3'd5, 3'd1, 3'd6};
    localparam logic [2:0]  V_CL  [NV] = '{3'd3, 3'd2, 3'd5, 3'd4, 3'd0, 3'd7, 3'd1, 3'd6};
    localparam logic        V_X16 [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [31:0] V_BE  [NV] = '{32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_C3A5,
                                           32'hFFFF_FFFF, 32'h000F_F0F0, 32'h0069_3CF1,
                                           32'hFFFF_FF3C, 32'h0123_4567};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   req_len = '0;
    logic [255:0] req_data = '0;
    logic [31:0]  req_be = '0;
    logic         mode_x16 = 1'b0;
    logic [2:0]   cas_lat = 3'd3;
    logic         busy, beat_valid, burst_last;
    logic [31:0]  beat_data;
    logic [3:0]   beat_dqm;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ddr_wm_gen u_ddr_wm_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
        .req_data(req_data), .req_be(req_be), .mode_x16(mode_x16), .cas_lat(cas_lat),
        .busy(busy), .beat_valid(beat_valid), .beat_data(beat_data),
        .beat_dqm(beat_dqm), .burst_last(burst_last)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk_word(input int v, input int k);
        return 32'hA500_0000 + 32'(v << 16) + 32'(k << 8) + 32'(k * 17);
    endfunction

    function automatic int wl_of(input logic [2:0] cl);
        if (cl < 3'd2) return 1;
        if (cl > 3'd5) return 4;
        return int'(cl) - 1;
    endfunction

    task automatic check_idle(input string req);
        chk(beat_valid == 1'b0, req, 32'(beat_valid), 32'd0);
        chk(beat_dqm == 4'hF, req, 32'(beat_dqm), 32'hF);
        chk(beat_data == 32'd0, req, beat_data, 32'd0);
        chk(burst_last == 1'b0, req, 32'(burst_last), 32'd0);
    endtask

    // One table vector: accept, disturb inputs, poke while busy, check every beat
    task automatic run_vec(input int v);
        int wl;
        logic [3:0]  ed;
        logic [31:0] ew;
        wl = wl_of(V_CL[v]);
        @(negedge clk);
        req_len  = V_LEN[v];
        req_be   = V_BE[v];
        mode_x16 = V_X16[v];
        cas_lat  = V_CL[v];
        for (int k = 0; k < 8; k++) req_data[k*32 +: 32] = mk_word(v, k);
        req_valid = 1'b1;
        for (int c = 1; c <= wl + 8; c++) begin
            @(negedge clk);
            if (c == 1) begin
                // R11: change every captured input after acceptance
                req_valid = 1'b0;
                req_data  = ~req_data;
                req_be    = ~req_be;
                req_len   = ~req_len;
                mode_x16  = ~mode_x16;
                cas_lat   = 3'd7 - cas_lat;
            end
            chk(busy == (c <= wl + 7), "R2 busy window", 32'(busy), 32'(c <= wl + 7));
            if (c >= wl && c <= wl + 7) begin
                int k;
                k = c - wl;
                chk(beat_valid == 1'b1, "R4/R5/R6 beat timing", 32'(beat_valid), 32'd1);
                if (k > int'(V_LEN[v])) begin
                    ed = 4'hF;
                    ew = 32'd0;
                end else begin
                    ed = ~V_BE[v][k*4 +: 4];
                    ew = mk_word(v, k);
                    if (V_X16[v]) begin
                        ed[3:2] = 2'b11;
                        ew[31:16] = 16'd0;
                    end
                end
                chk(beat_dqm == ed, "R7/R8/R9/R11 dqm", 32'(beat_dqm), 32'(ed));
                chk(beat_data == ew, "R7/R8/R9/R11 data", beat_data, ew);
                chk(burst_last == (k == 7), "R6 last beat", 32'(burst_last), 32'(k == 7));
            end else begin
                check_idle("R10 outside burst");
            end
            if (c == 2) req_valid = 1'b1;  // R3: request while busy
            if (c == 3) req_valid = 1'b0;
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(beat_valid == 1'b0 && busy == 1'b0, "R3 blocked request dropped",
                32'(beat_valid), 32'd0);
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: state during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", 32'(busy), 32'd0);
        check_idle("R1 reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        for (int v = 0; v < NV; v++) run_vec(v);

        // R2: held request is accepted in the cycle after the last beat (WL = 1)
        @(negedge clk);
        req_len = 3'd7; req_be = 32'hFFFF_FFFF; mode_x16 = 1'b0; cas_lat = 3'd2;
        for (int k = 0; k < 8; k++) req_data[k*32 +: 32] = mk_word(9, k);
        req_valid = 1'b1;
        for (int c = 1; c <= 10; c++) begin
            @(negedge clk);
            if (c == 8) chk(burst_last == 1'b1, "R6 last of first burst", 32'(burst_last), 32'd1);
            if (c == 9) begin
                chk(busy == 1'b0, "R2 free after last beat", 32'(busy), 32'd0);
                chk(beat_valid == 1'b0, "R2 gap cycle", 32'(beat_valid), 32'd0);
            end
            if (c == 10) begin
                chk(beat_valid == 1'b1, "R2 held request restarts", 32'(beat_valid), 32'd1);
                chk(beat_data == mk_word(9, 0), "R2 restart data", beat_data, mk_word(9, 0));
                req_valid = 1'b0;
            end
        end
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R2 second burst done", 32'(busy), 32'd0);

        // R1: reset in the middle of a burst
        req_valid = 1'b1; cas_lat = 3'd3;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(beat_valid == 1'b1, "R1 burst running before reset", 32'(beat_valid), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 mid-burst reset busy", 32'(busy), 32'd0);
        check_idle("R1 mid-burst reset outputs");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1 stays idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule